// File: doc/BRIEF.md
# Iterative Mantissa Divider and Square Root

This block turns normalized significands, hidden bit included, into a quotient or a square root, one result bit per clock. It is the slow, area-lean arithmetic engine behind a floating-point unit. The unit scales every operand to a wide internal format beforehand, so the core only ever sees normalized mantissas. Exponent arithmetic, special operands, rounding and packing are handled around it.

The core is not pipelined. A caller raises `start` for one cycle with the operation, the precision and the operands. It then waits for the one-cycle `done` pulse. `res_q` then holds the truncated result with extra low bits for rounding. `sticky` tells whether anything was left in the remainder.

Divide and root share the remainder, result and counter registers. Each has its own restoring step. For a root with an odd unbiased exponent, the caller sets `odd_exp` and the radicand is doubled before the recurrence starts.

Top module: `fdsq_core`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `res_q` and `sticky` are all 0.
- R2: A `start` seen while `busy` is low is accepted, and `busy` is 1 from the next cycle. `done` is a one-cycle pulse, during which `busy` is already 0.
- R3: While `busy` is 1, `start` and any change on the operation, precision or operand inputs have no effect on the running operation, and cause no extra `done` pulse.
- R4: For a divide (`op_sqrt`=0), let F be the active fraction width and A, B the active mantissas as integers. `res_q` equals floor(A·2^(F+3)/B), so one of bits F+3 and F+2 is always 1.
- R5: For a root (`op_sqrt`=1), let X = A·2 when `odd_exp`=1 and X = A otherwise. `res_q` equals floor(sqrt(X·2^(F+4))), so bit F+2 is 1 and bit F+3 is 0.
- R6: `sticky` is 1 exactly when the result is inexact. For a divide that means A·2^(F+3) is not a multiple of B. For a root it means `res_q`² differs from X·2^(F+4).
- R7: `done` rises L clock edges after the accepting edge. For a divide L = F+6, and for a root L = F+5. With the default widths this gives 29 and 28 cycles in single precision and 58 and 57 in double.
- R8: With `dbl`=1, F = FRAC_D and the whole mantissa is used. With `dbl`=0, F = FRAC_S and only the top FRAC_S+1 bits of each mantissa count; the lower bits are ignored. The result is right-aligned, with all bits above F+3 at 0.
- R9: `mant_b` has no effect on a root, and `odd_exp` has no effect on a divide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation (taken only when idle) |
| op_sqrt | input | 1 | 0 = divide `mant_a` by `mant_b`, 1 = square root of `mant_a` |
| dbl | input | 1 | 1 = wide precision, 0 = narrow precision |
| odd_exp | input | 1 | Root only: unbiased exponent is odd, so the radicand is doubled |
| mant_a | input | FRAC_D+1 | Dividend or radicand, hidden bit at the MSB |
| mant_b | input | FRAC_D+1 | Divisor, hidden bit at the MSB |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| res_q | output | FRAC_D+4 | Truncated quotient or root, with guard bits |
| sticky | output | 1 | Final remainder is nonzero |

## Verification
The bench sweeps every normalized divisor and dividend pair, and every radicand with both exponent parities, in a reduced wide/narrow configuration.

Several corner cases are targeted directly:
- Equal operands and exact roots pin the sticky bit to 0; a design that flagged a spurious remainder would round exact results away.
- In narrow mode, the low mantissa bits are filled with noise. A core that failed to drop them would produce quotients that differ for identical narrow values.
- Some operations carry a second `start` and scrambled inputs mid-flight. A core that re-armed or relatched would return the wrong result or pulse `done` twice.
- Every operation is timed from acceptance to `done`. An off-by-one in the iteration counter shows up as a latency mismatch and a result shifted by one bit.

// File: rtl/fdsq_pkg.sv
package fdsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_ITER,
    ST_FIN
  } fdsq_state_e;

  // result bits produced by the recurrence for a given active fraction width
  function automatic int iter_count(input logic is_root, input int frac_w);
    return is_root ? frac_w + 3 : frac_w + 4;
  endfunction

  // clock edges from acceptance to the done pulse
  function automatic int op_latency(input logic is_root, input int frac_w);
    return iter_count(is_root, frac_w) + 2;
  endfunction

endpackage

// File: rtl/fdsq_ctrl.sv
module fdsq_ctrl
  import fdsq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] n_iter,
  output logic             accept,
  output logic             load,
  output logic             step,
  output logic             finish,
  output logic             busy
);

  fdsq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept = start && (state_q == ST_IDLE);
  assign load   = (state_q == ST_PREP);
  assign step   = (state_q == ST_ITER);
  assign finish = (state_q == ST_FIN);
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_PREP;
        ST_PREP: begin
          cnt_q   <= n_iter - CNT_W'(1);
          state_q <= ST_ITER;
        end
        ST_ITER: begin
          if (cnt_q == '0) state_q <= ST_FIN;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fdsq_div_step.sv
module fdsq_div_step #(
  parameter int REM_W  = 10,
  parameter int MANT_W = 5
) (
  input  logic [REM_W-1:0]  rem,
  input  logic [MANT_W-1:0] dvs,
  output logic [REM_W-1:0]  rem_nx,
  output logic              q_bit
);

  logic [REM_W:0]   diff;
  logic [REM_W-1:0] kept;

  always_comb begin
    diff   = {1'b0, rem} - {{(REM_W-MANT_W+1){1'b0}}, dvs};
    q_bit  = ~diff[REM_W];
    kept   = q_bit ? diff[REM_W-1:0] : rem;
    rem_nx = {kept[REM_W-2:0], 1'b0};
  end

endmodule

// File: rtl/fdsq_sqrt_step.sv
module fdsq_sqrt_step #(
  parameter int REM_W = 10,
  parameter int RES_W = 8
) (
  input  logic [REM_W-1:0] rem,
  input  logic [RES_W-1:0] root,
  input  logic [1:0]       pair,
  output logic [REM_W-1:0] rem_nx,
  output logic             r_bit
);

  logic [REM_W+1:0] cur;
  logic [REM_W+1:0] trial;
  logic [REM_W+2:0] diff;

  always_comb begin
    cur    = {rem, pair};
    trial  = {{(REM_W-RES_W){1'b0}}, root, 2'b01};
    diff   = {1'b0, cur} - {1'b0, trial};
    r_bit  = ~diff[REM_W+2];
    rem_nx = r_bit ? diff[REM_W-1:0] : cur[REM_W-1:0];
  end

endmodule

// File: rtl/fdsq_core.sv
module fdsq_core
  import fdsq_pkg::*;
#(
  parameter int FRAC_D = 52,
  parameter int FRAC_S = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sqrt,
  input  logic              dbl,
  input  logic              odd_exp,
  input  logic [FRAC_D:0]   mant_a,
  input  logic [FRAC_D:0]   mant_b,
  output logic              busy,
  output logic              done,
  output logic [FRAC_D+3:0] res_q,
  output logic              sticky
);

  localparam int MANT_W = FRAC_D + 1;
  localparam int RES_W  = FRAC_D + 4;
  localparam int REM_W  = FRAC_D + 6;
  localparam int RAD_W  = 2 * FRAC_D + 6;
  localparam int CNT_W  = $clog2(RES_W + 1);
  localparam int SH     = FRAC_D - FRAC_S;

  // operation latched at acceptance
  logic              op_q, dbl_q, odd_q;
  logic [MANT_W-1:0] a_q, b_q;

  // shared recurrence state
  logic [REM_W-1:0] rem_q;
  logic [RES_W-1:0] acc_q;
  logic [RAD_W-1:0] rad_q;

  // control events, named for the checker
  logic accept, load, step, finish;
  logic [CNT_W-1:0] n_iter;

  logic [MANT_W-1:0] a_act, b_act;
  logic [MANT_W:0]   rad_x;
  logic [RAD_W-1:0]  rad_init;
  logic [REM_W-1:0]  dv_rem_nx, sq_rem_nx;
  logic              dv_bit, sq_bit;

  assign a_act    = dbl_q ? a_q : (a_q >> SH);
  assign b_act    = dbl_q ? b_q : (b_q >> SH);
  assign rad_x    = odd_q ? {a_act, 1'b0} : {1'b0, a_act};
  assign rad_init = {{(RAD_W-MANT_W-1){1'b0}}, rad_x} << (dbl_q ? FRAC_D + 4 : FRAC_D + 4 + SH);
  assign n_iter   = CNT_W'(iter_count(op_q, dbl_q ? FRAC_D : FRAC_S));

  fdsq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .n_iter (n_iter),
    .accept (accept),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy)
  );

  fdsq_div_step #(.REM_W(REM_W), .MANT_W(MANT_W)) u_div (
    .rem    (rem_q),
    .dvs    (b_act),
    .rem_nx (dv_rem_nx),
    .q_bit  (dv_bit)
  );

  fdsq_sqrt_step #(.REM_W(REM_W), .RES_W(RES_W)) u_sqrt (
    .rem    (rem_q),
    .root   (acc_q),
    .pair   (rad_q[RAD_W-1 -: 2]),
    .rem_nx (sq_rem_nx),
    .r_bit  (sq_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= 1'b0;
      dbl_q <= 1'b0;
      odd_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (accept) begin
      op_q  <= op_sqrt;
      dbl_q <= dbl;
      odd_q <= odd_exp;
      a_q   <= mant_a;
      b_q   <= mant_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      rad_q <= '0;
    end else if (load) begin
      rem_q <= op_q ? '0 : {{(REM_W-MANT_W){1'b0}}, a_act};
      acc_q <= '0;
      rad_q <= op_q ? rad_init : '0;
    end else if (step) begin
      rem_q <= op_q ? sq_rem_nx : dv_rem_nx;
      acc_q <= {acc_q[RES_W-2:0], op_q ? sq_bit : dv_bit};
      rad_q <= {rad_q[RAD_W-3:0], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      res_q  <= '0;
      sticky <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        res_q  <= acc_q;
        sticky <= |rem_q;
      end
    end
  end

endmodule

// File: rtl/fdsq_core_chk.sv
module fdsq_core_chk
  import fdsq_pkg::*;
#(
  parameter int FRAC_D = 52,
  parameter int FRAC_S = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              op_sqrt,
  input logic              dbl,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic [FRAC_D+3:0] res_q
);

  logic        sq_l, dbl_l;
  logic [15:0] lat_cnt;
  int          f_l, exp_lat;

  assign f_l     = dbl_l ? FRAC_D : FRAC_S;
  assign exp_lat = op_latency(sq_l, f_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_l    <= 1'b0;
      dbl_l   <= 1'b0;
      lat_cnt <= '0;
    end else if (start && !busy) begin
      sq_l    <= op_sqrt;
      dbl_l   <= dbl;
      lat_cnt <= '0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !done));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(lat_cnt) == exp_lat));

  assert_quot_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sq_l) |-> (res_q[f_l+3] || res_q[f_l+2]));

  assert_root_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sq_l) |-> (res_q[f_l+2] && !res_q[f_l+3]));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dbl_l) |-> ((res_q >> (FRAC_S + 4)) == '0));

endmodule

bind fdsq_core fdsq_core_chk #(.FRAC_D(FRAC_D), .FRAC_S(FRAC_S)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .op_sqrt (op_sqrt),
  .dbl     (dbl),
  .busy    (busy),
  .done    (done),
  .accept  (accept),
  .res_q   (res_q)
);

// File: tb/fdsq_core_bench.sv
module fdsq_core_bench;

  localparam int FD = 6;
  localparam int FS = 3;
  localparam int MW = FD + 1;
  localparam int RW = FD + 4;
  localparam int SH = FD - FS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_sqrt = 1'b0;
  logic          dbl = 1'b0;
  logic          odd_exp = 1'b0;
  logic [MW-1:0] mant_a = '0;
  logic [MW-1:0] mant_b = '0;
  logic          busy, done, sticky;
  logic [RW-1:0] res_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fdsq_core #(.FRAC_D(FD), .FRAC_S(FS)) u_fdsq_core (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sqrt(op_sqrt), .dbl(dbl),
    .odd_exp(odd_exp), .mant_a(mant_a), .mant_b(mant_b), .busy(busy),
    .done(done), .res_q(res_q), .sticky(sticky)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic run_op(input logic sq, input logic dp, input logic od,
                        input logic [MW-1:0] a, input logic [MW-1:0] b,
                        input bit poke, input string rtag);
    int k;
    int f;
    longint aa, bb, x, v, eq;
    bit es;
    int el;
    f  = dp ? FD : FS;
    aa = dp ? longint'(a) : longint'(a >> SH);
    bb = dp ? longint'(b) : longint'(b >> SH);
    if (!sq) begin
      v  = aa << (f + 3);
      eq = v / bb;
      es = (v % bb) != 0;
      el = f + 6;
    end else begin
      x  = od ? aa * 2 : aa;
      v  = x << (f + 4);
      eq = isqrt(v);
      es = (eq * eq) != v;
      el = f + 5;
    end
    @(negedge clk);
    start = 1'b1; op_sqrt = sq; dbl = dp; odd_exp = od; mant_a = a; mant_b = b;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    if (poke) begin
      chk(busy === 1'b1, "R2", "busy after accept", longint'(busy), 1);
      start = 1'b1; op_sqrt = ~sq; dbl = ~dp; odd_exp = ~od; mant_a = ~a; mant_b = ~b;
    end
    while (done !== 1'b1 && k < 200) begin
      @(negedge clk);
      k++;
      if (k == 3) start = 1'b0;
    end
    chk(k == el, "R7", "latency", k, el);
    chk(res_q == RW'(eq), rtag, "result", longint'(res_q), eq);
    chk(sticky == es, "R6", "sticky", longint'(sticky), longint'(es));
    chk(busy === 1'b0, "R2", "busy low with done", longint'(busy), 0);
    if (poke) begin
      for (int j = 0; j < el + 3; j++) begin
        @(negedge clk);
        if (done !== 1'b0) break;
      end
      chk(done === 1'b0, "R3", "no second done", longint'(done), 0);
    end
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", longint'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", longint'({busy, done}), 0);
    chk(res_q === '0 && sticky === 1'b0, "R1", "result after reset", longint'(res_q), 0);

    // wide divide, full sweep; odd_exp toggled as noise (R9)
    cnt = 0;
    for (int a = 64; a < 128; a++)
      for (int b = 64; b < 128; b++) begin
        cnt++;
        run_op(1'b0, 1'b1, 1'($urandom), MW'(a), MW'(b), (cnt % 97) == 0, "R4 R9");
      end

    // wide root, both parities; mant_b is noise (R9)
    for (int a = 64; a < 128; a++)
      for (int od = 0; od < 2; od++)
        run_op(1'b1, 1'b1, 1'(od), MW'(a), MW'($urandom), (a % 13) == 0, "R5 R9");

    // narrow divide: low bits filled with noise (R8)
    for (int a = 8; a < 16; a++)
      for (int b = 8; b < 16; b++)
        run_op(1'b0, 1'b0, 1'b0, MW'((a << SH) | ($urandom % 8)),
               MW'((b << SH) | ($urandom % 8)), (a == b), "R4 R8");

    // narrow root (R8)
    for (int a = 8; a < 16; a++)
      for (int od = 0; od < 2; od++)
        run_op(1'b1, 1'b0, 1'(od), MW'((a << SH) | ($urandom % 8)), MW'($urandom),
               (a == 9), "R5 R8");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule